// File: doc/BRIEF.md
# Integer Trivial Operation Bypass Unit

This unit sits next to a 32-bit integer execution path and looks at each operation before it is dispatched. It sees an opcode and two operands, X and Y, and each operand has its own valid flag. When the outcome can be known without running the operation, the unit decides this cycle. It either supplies the result directly (a bypass) or hands the operation to the shifter as a single shift (a simplify). Otherwise it marks the operation for normal execution.

The normal path costs 1 cycle in the ALU, 3 cycles in the multiplier and 19 cycles in the divider. A bypass saves that latency, and a simplify replaces a multiply or divide with a one-cycle shift. A bypass whose result is a constant fires as soon as the operand that decides it is valid, without waiting for the other operand. This lets a scheduler release dependants early. The decision is registered, so every output is due one clock after the request is sampled.

The parameter `EN_SIMPLIFY` chooses between two variants. When it is 0, the power-of-two hardware is left out and those operations go to normal execution.

Top module: `trivial_bypass_unit`

## Requirements
- R1: While `rst_n` is low, and on the cycle after any edge that samples `in_valid` low, all three flags `byp_o`, `simp_o` and `norm_o` are low.
- R2: Each decision appears on the outputs exactly one clock after the edge that samples its inputs. At most one of `byp_o`, `simp_o` and `norm_o` is high in any cycle. A bypass takes priority over a simplify.
- R3: Add (opcode 0) with both operands valid: if X is 0 the bypassed result is Y; otherwise, if Y is 0, the result is X.
- R4: Subtract (opcode 1) with both operands valid: Y equal to 0 bypasses with X, and X equal to Y bypasses with 0.
- R5: Multiply (opcode 2) bypasses with 0 when a valid operand equals 0, even if the other operand is not valid.
- R6: Multiply with both operands valid and neither one zero: if X is a power of two, the unit simplifies to a left shift (`simp_dir`=0) of Y by log2(X). Otherwise, if Y is a power of two, it simplifies to a left shift of X by log2(Y).
- R7: Divide (opcode 3) is unsigned, needs both operands valid, and never bypasses when Y is 0; it goes to normal execution. With Y nonzero, X equal to 0 bypasses with 0, and then X equal to Y bypasses with 1.
- R8: Divide by a nonzero, non-trivial power-of-two Y simplifies to a logical right shift (`simp_dir`=1) of X by log2(Y).
- R9: With only one operand valid, AND (opcode 4) bypasses with 0 when that operand is 0. OR (opcode 5) bypasses with all ones when that operand is all ones.
- R10: With both operands valid, AND, OR and XOR (opcode 6) are bypassed as follows:
  - AND and OR return the other operand when one operand is their identity (all ones for AND, 0 for OR).
  - AND and OR return X when X equals Y.
  - XOR returns the other operand when one operand is 0.
  - XOR returns 0 when X equals Y.
  - XOR returns the inverse of the other operand when one operand is all ones.
- R11: For logical shifts (opcode 7 left, opcode 8 right), X is the value and the shift amount is the low log2(WIDTH) bits of Y; the upper bits of Y are ignored. A valid X of 0 bypasses with 0 on its own. An amount of 0 bypasses with X.
- R12: Arithmetic right shift (opcode 9): a valid X of 0 or all ones bypasses with X, even if Y is not valid. With both operands valid, an amount of 0 bypasses with X.
- R13: A request with both operands valid that no rule covers, including opcodes 10 to 15, raises `norm_o`. A request with a missing operand that no rule covers raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| in_op | input | 4 | Opcode (0 add ... 9 arithmetic shift) |
| x_data | input | WIDTH | Operand X (shift value, dividend) |
| x_vld | input | 1 | Operand X is valid |
| y_data | input | WIDTH | Operand Y (shift amount, divisor) |
| y_vld | input | 1 | Operand Y is valid |
| byp_o | output | 1 | The result is supplied on `byp_result` |
| byp_result | output | WIDTH | Bypassed result |
| simp_o | output | 1 | Issue to the shifter instead |
| simp_dir | output | 1 | 0 shift left, 1 logical shift right |
| simp_value | output | WIDTH | Value to shift |
| simp_amt | output | log2(WIDTH) | Shift amount |
| norm_o | output | 1 | Send to normal execution |

## Verification
Every result is due in the first cycle after the rising edge that samples the request. The bench drives each request on a falling edge and compares one nanosecond after the next rising edge, against a model that it evaluates on that same request. Bypass data is compared only when a bypass is expected, and shift fields only when a simplify is expected. The flags are compared on every cycle, including the idle cycles and the cycles during reset. Because a single-operand bypass must not wait, many requests carry exactly one valid operand, and the bench requires the result in that same next cycle.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_MUL = 4'd2,
      OP_DIV = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_SLL = 4'd7,
      OP_SRL = 4'd8,
      OP_SRA = 4'd9
   } op_t;

   typedef enum logic [1:0] {
      RT_WAIT = 2'd0,
      RT_BYP  = 2'd1,
      RT_SIMP = 2'd2,
      RT_NORM = 2'd3
   } route_t;

   localparam logic DIR_LEFT  = 1'b0;
   localparam logic DIR_RIGHT = 1'b1;

endpackage

// File: rtl/tbu_pow2.sv
module tbu_pow2 #(
   parameter int WIDTH = 32,
   localparam int SHW = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] v,
   output logic             is_p2,
   output logic [SHW-1:0]   lg
);
   logic [WIDTH-1:0] v_m1;

   assign v_m1  = v - WIDTH'(1);
   assign is_p2 = (v != '0) && ((v & v_m1) == '0);

   // priority encoder: index of the highest set bit
   always_comb begin
      lg = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (v[i]) lg = SHW'(i);
      end
   end
endmodule

// File: rtl/tbu_detect.sv
module tbu_detect
   import tbu_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW = $clog2(WIDTH)
) (
   input  logic             req,
   input  op_t              op,
   input  logic [WIDTH-1:0] x,
   input  logic             xv,
   input  logic [WIDTH-1:0] y,
   input  logic             yv,
   input  logic             x_p2,
   input  logic [SHW-1:0]   x_lg,
   input  logic             y_p2,
   input  logic [SHW-1:0]   y_lg,
   output route_t           route,
   output logic [WIDTH-1:0] res,
   output logic             sdir,
   output logic [WIDTH-1:0] sval,
   output logic [SHW-1:0]   samt
);
   logic both, x_z, y_z, x_o, y_o, same, amt_z;

   assign both  = xv && yv;
   assign x_z   = (x == '0);
   assign y_z   = (y == '0);
   assign x_o   = (x == '1);
   assign y_o   = (y == '1);
   assign same  = (x == y);
   assign amt_z = (y[SHW-1:0] == '0);

   always_comb begin
      route = RT_WAIT;
      res   = '0;
      sdir  = DIR_LEFT;
      sval  = '0;
      samt  = '0;
      if (req) begin
         unique case (op)
            OP_ADD: begin
               if (both) begin
                  if (x_z)      begin route = RT_BYP; res = y; end
                  else if (y_z) begin route = RT_BYP; res = x; end
                  else route = RT_NORM;
               end
            end
            OP_SUB: begin
               if (both) begin
                  if (y_z)       begin route = RT_BYP; res = x;  end
                  else if (same) begin route = RT_BYP; res = '0; end
                  else route = RT_NORM;
               end
            end
            OP_MUL: begin
               if ((xv && x_z) || (yv && y_z)) begin
                  route = RT_BYP; res = '0;
               end else if (both) begin
                  if (x_p2) begin
                     route = RT_SIMP; sdir = DIR_LEFT; sval = y; samt = x_lg;
                  end else if (y_p2) begin
                     route = RT_SIMP; sdir = DIR_LEFT; sval = x; samt = y_lg;
                  end else route = RT_NORM;
               end
            end
            OP_DIV: begin
               if (both) begin
                  if (y_z)       route = RT_NORM;
                  else if (x_z)  begin route = RT_BYP; res = '0; end
                  else if (same) begin route = RT_BYP; res = WIDTH'(1); end
                  else if (y_p2) begin
                     route = RT_SIMP; sdir = DIR_RIGHT; sval = x; samt = y_lg;
                  end else route = RT_NORM;
               end
            end
            OP_AND: begin
               if ((xv && x_z) || (yv && y_z)) begin
                  route = RT_BYP; res = '0;
               end else if (both) begin
                  if (x_o)       begin route = RT_BYP; res = y; end
                  else if (y_o)  begin route = RT_BYP; res = x; end
                  else if (same) begin route = RT_BYP; res = x; end
                  else route = RT_NORM;
               end
            end
            OP_OR: begin
               if ((xv && x_o) || (yv && y_o)) begin
                  route = RT_BYP; res = '1;
               end else if (both) begin
                  if (x_z)       begin route = RT_BYP; res = y; end
                  else if (y_z)  begin route = RT_BYP; res = x; end
                  else if (same) begin route = RT_BYP; res = x; end
                  else route = RT_NORM;
               end
            end
            OP_XOR: begin
               if (both) begin
                  if (x_z)       begin route = RT_BYP; res = y;  end
                  else if (y_z)  begin route = RT_BYP; res = x;  end
                  else if (same) begin route = RT_BYP; res = '0; end
                  else if (x_o)  begin route = RT_BYP; res = ~y; end
                  else if (y_o)  begin route = RT_BYP; res = ~x; end
                  else route = RT_NORM;
               end
            end
            OP_SLL, OP_SRL: begin
               if (xv && x_z) begin
                  route = RT_BYP; res = '0;
               end else if (both) begin
                  if (amt_z) begin route = RT_BYP; res = x; end
                  else route = RT_NORM;
               end
            end
            OP_SRA: begin
               if (xv && (x_z || x_o)) begin
                  route = RT_BYP; res = x;
               end else if (both) begin
                  if (amt_z) begin route = RT_BYP; res = x; end
                  else route = RT_NORM;
               end
            end
            default: begin
               if (both) route = RT_NORM;
            end
         endcase
      end
   end
endmodule

// File: rtl/tbu_outreg.sv
module tbu_outreg
   import tbu_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  route_t           route,
   input  logic [WIDTH-1:0] res,
   input  logic             sdir,
   input  logic [WIDTH-1:0] sval,
   input  logic [SHW-1:0]   samt,
   output logic             byp_q,
   output logic [WIDTH-1:0] res_q,
   output logic             simp_q,
   output logic             dir_q,
   output logic [WIDTH-1:0] sval_q,
   output logic [SHW-1:0]   samt_q,
   output logic             norm_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q  <= 1'b0;
         simp_q <= 1'b0;
         norm_q <= 1'b0;
         res_q  <= '0;
         dir_q  <= 1'b0;
         sval_q <= '0;
         samt_q <= '0;
      end else begin
         byp_q  <= (route == RT_BYP);
         simp_q <= (route == RT_SIMP);
         norm_q <= (route == RT_NORM);
         res_q  <= res;
         dir_q  <= sdir;
         sval_q <= sval;
         samt_q <= samt;
      end
   end
endmodule

// File: rtl/trivial_bypass_unit.sv
module trivial_bypass_unit
   import tbu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit EN_SIMPLIFY = 1'b1,
   localparam int SHW = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [3:0]       in_op,
   input  logic [WIDTH-1:0] x_data,
   input  logic             x_vld,
   input  logic [WIDTH-1:0] y_data,
   input  logic             y_vld,
   output logic             byp_o,
   output logic [WIDTH-1:0] byp_result,
   output logic             simp_o,
   output logic             simp_dir,
   output logic [WIDTH-1:0] simp_value,
   output logic [SHW-1:0]   simp_amt,
   output logic             norm_o
);
   if (WIDTH < 8 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("trivial_bypass_unit: WIDTH must be a power of two of at least 8");
   end

   op_t              op_c;
   logic             x_p2, y_p2;
   logic [SHW-1:0]   x_lg, y_lg;
   route_t           route;
   logic [WIDTH-1:0] res_c, sval_c;
   logic             sdir_c;
   logic [SHW-1:0]   samt_c;

   assign op_c = op_t'(in_op);

   if (EN_SIMPLIFY) begin : g_simp
      tbu_pow2 #(.WIDTH(WIDTH)) i_x_p2 (.v(x_data), .is_p2(x_p2), .lg(x_lg));
      tbu_pow2 #(.WIDTH(WIDTH)) i_y_p2 (.v(y_data), .is_p2(y_p2), .lg(y_lg));
   end else begin : g_no_simp
      assign x_p2 = 1'b0;
      assign y_p2 = 1'b0;
      assign x_lg = '0;
      assign y_lg = '0;
   end

   tbu_detect #(.WIDTH(WIDTH)) i_detect (
      .req(in_valid), .op(op_c),
      .x(x_data), .xv(x_vld), .y(y_data), .yv(y_vld),
      .x_p2(x_p2), .x_lg(x_lg), .y_p2(y_p2), .y_lg(y_lg),
      .route(route), .res(res_c), .sdir(sdir_c), .sval(sval_c), .samt(samt_c)
   );

   tbu_outreg #(.WIDTH(WIDTH)) i_outreg (
      .clk(clk), .rst_n(rst_n),
      .route(route), .res(res_c), .sdir(sdir_c), .sval(sval_c), .samt(samt_c),
      .byp_q(byp_o), .res_q(byp_result), .simp_q(simp_o), .dir_q(simp_dir),
      .sval_q(simp_value), .samt_q(simp_amt), .norm_q(norm_o)
   );

   AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !byp_o && !simp_o && !norm_o);                        // R1
   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byp_o, simp_o, norm_o}));                                   // R2
   AST_ADD_ZERO_X: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == 4'd0 && x_vld && y_vld && x_data == '0
      |=> byp_o && byp_result == $past(y_data));                            // R3
   AST_SUB_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == 4'd1 && x_vld && y_vld && y_data != '0 && x_data == y_data
      |=> byp_o && byp_result == '0);                                       // R4
   AST_MUL_ZERO_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == 4'd2 && x_vld && !y_vld && x_data == '0
      |=> byp_o && byp_result == '0);                                       // R5
   AST_DIV_BY_ZERO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == 4'd3 && x_vld && y_vld && y_data == '0
      |=> norm_o);                                                          // R7
   AST_DIV_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      simp_o && $past(in_op) == 4'd3 |-> simp_dir == DIR_RIGHT);            // R8
   AST_OR_ONES_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == 4'd5 && y_vld && y_data == '1
      |=> byp_o && byp_result == '1);                                       // R9
   AST_XOR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == 4'd6 && x_vld && y_vld && x_data == y_data
      && x_data != '0
      |=> byp_o && byp_result == '0);                                       // R10
   AST_SHIFT_ZERO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_op == 4'd7 || in_op == 4'd8) && x_vld && x_data == '0
      |=> byp_o && byp_result == '0);                                       // R11
   AST_SRA_ONES_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_op == 4'd9 && x_vld && x_data == '1
      |=> byp_o && byp_result == '1);                                       // R12
   AST_NORM_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      norm_o |-> $past(x_vld) && $past(y_vld));                             // R13
endmodule

// File: tb/test_trivial_bypass_unit.sv
`timescale 1ns/1ps
module test_trivial_bypass_unit;
   localparam int W = 32;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [3:0]    in_op = '0;
   logic [W-1:0]  x_data = '0, y_data = '0;
   logic          x_vld = 1'b0, y_vld = 1'b0;
   logic          byp_o, simp_o, simp_dir, norm_o;
   logic [W-1:0]  byp_result, simp_value;
   logic [SW-1:0] simp_amt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   trivial_bypass_unit #(.WIDTH(W)) i_trivial_bypass_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .x_data(x_data), .x_vld(x_vld), .y_data(y_data), .y_vld(y_vld),
      .byp_o(byp_o), .byp_result(byp_result), .simp_o(simp_o),
      .simp_dir(simp_dir), .simp_value(simp_value), .simp_amt(simp_amt),
      .norm_o(norm_o)
   );

   // expected outputs
   logic          e_byp, e_simp, e_norm, e_dir;
   logic [W-1:0]  e_res, e_val;
   logic [SW-1:0] e_amt;
   string         e_tag;

   function automatic int log2_of(input logic [W-1:0] v);
      int k = 0;
      while (k < W && v != (W'(1) << k)) k++;
      return k;
   endfunction

   function automatic bit pow2(input logic [W-1:0] v);
      return $countones(v) == 1;
   endfunction

   task automatic give(input logic [W-1:0] r, input string t);
      e_byp = 1'b1; e_res = r; e_tag = t;
   endtask

   task automatic shift_to(input logic d, input logic [W-1:0] v,
                           input logic [W-1:0] pw, input string t);
      e_simp = 1'b1; e_dir = d; e_val = v; e_amt = SW'(log2_of(pw)); e_tag = t;
   endtask

   task automatic model(input bit iv, input int op, input logic [W-1:0] x,
                        input bit xv, input logic [W-1:0] y, input bit yv);
      bit both = xv && yv;
      logic [W-1:0] ones = '1;
      e_byp = 0; e_simp = 0; e_norm = 0; e_dir = 0;
      e_res = '0; e_val = '0; e_amt = '0; e_tag = "R2";
      if (!iv) begin
         e_tag = "R1";
         return;
      end
      case (op)
         0: if (both) begin
               if (x == 0) give(y, "R3");
               else if (y == 0) give(x, "R3");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         1: if (both) begin
               if (y == 0) give(x, "R4");
               else if (x == y) give('0, "R4");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         2: if ((xv && x == 0) || (yv && y == 0)) give('0, "R5");
            else if (both) begin
               if (pow2(x)) shift_to(0, y, x, "R6");
               else if (pow2(y)) shift_to(0, x, y, "R6");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         3: if (both) begin
               if (y == 0) begin e_norm = 1; e_tag = "R7"; end
               else if (x == 0) give('0, "R7");
               else if (x == y) give(W'(1), "R7");
               else if (pow2(y)) shift_to(1, x, y, "R8");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         4: if ((xv && x == 0) || (yv && y == 0)) give('0, "R9");
            else if (both) begin
               if (x == ones) give(y, "R10");
               else if (y == ones || x == y) give(x, "R10");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         5: if ((xv && x == ones) || (yv && y == ones)) give(ones, "R9");
            else if (both) begin
               if (x == 0) give(y, "R10");
               else if (y == 0 || x == y) give(x, "R10");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         6: if (both) begin
               if (x == 0) give(y, "R10");
               else if (y == 0) give(x, "R10");
               else if (x == y) give('0, "R10");
               else if (x == ones) give(~y, "R10");
               else if (y == ones) give(~x, "R10");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         7, 8: if (xv && x == 0) give('0, "R11");
            else if (both) begin
               if (y % W == 0) give(x, "R11");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         9: if (xv && (x == 0 || x == ones)) give(x, "R12");
            else if (both) begin
               if (y % W == 0) give(x, "R12");
               else begin e_norm = 1; e_tag = "R13"; end
            end
         default: if (both) begin e_norm = 1; e_tag = "R13"; end
      endcase
   endtask

   task automatic compare();
      bit bad;
      checks++;
      bad = (byp_o !== e_byp) || (simp_o !== e_simp) || (norm_o !== e_norm);
      if (e_byp && byp_result !== e_res) bad = 1;
      if (e_simp && (simp_dir !== e_dir || simp_value !== e_val || simp_amt !== e_amt))
         bad = 1;
      if (bad) begin
         fails++;
         $display("FAIL %s op=%0d x=%h/%0b y=%h/%0b got b%0b s%0b n%0b r=%h d%0b v=%h a=%0d exp b%0b s%0b n%0b r=%h d%0b v=%h a=%0d",
                  e_tag, in_op, x_data, x_vld, y_data, y_vld,
                  byp_o, simp_o, norm_o, byp_result, simp_dir, simp_value, simp_amt,
                  e_byp, e_simp, e_norm, e_res, e_dir, e_val, e_amt);
      end
   endtask

   task automatic apply(input bit iv, input int op, input logic [W-1:0] x,
                        input bit xv, input logic [W-1:0] y, input bit yv);
      @(negedge clk);
      in_valid = iv; in_op = 4'(op); x_data = x; x_vld = xv; y_data = y; y_vld = yv;
      model(iv, op, x, xv, y, yv);
      @(posedge clk);
      #1;
      compare();
   endtask

   function automatic logic [W-1:0] pick(input logic [W-1:0] other);
      case ($urandom_range(0, 7))
         0: return '0;
         1: return '1;
         2: return W'(1) << $urandom_range(0, W-1);
         3: return other;
         4: return W'(1);
         5: return W'($urandom_range(0, 40));
         default: return W'($urandom);
      endcase
   endfunction

   initial begin
      // R1 reset state
      #2;
      e_byp = 0; e_simp = 0; e_norm = 0; e_tag = "R1";
      repeat (3) @(posedge clk);
      #1 compare();
      @(negedge clk) rst_n = 1'b1;

      apply(0, 0, 32'h0, 1, 32'h5, 1);                 // R1 idle
      apply(1, 0, 32'h0, 1, 32'h1234, 1);              // R3
      apply(1, 0, 32'h77, 1, 32'h0, 1);                // R3
      apply(1, 0, 32'h0, 1, 32'h9, 0);                 // R3 needs both: wait
      apply(1, 1, 32'h55, 1, 32'h0, 1);                // R4
      apply(1, 1, 32'habc, 1, 32'habc, 1);             // R4
      apply(1, 2, 32'h0, 1, 32'hdead, 0);              // R5 single operand
      apply(1, 2, 32'hbeef, 0, 32'h0, 1);              // R5 single operand
      apply(1, 2, 32'h10, 1, 32'h3, 1);                // R6 X power of two
      apply(1, 2, 32'h7, 1, 32'h80000000, 1);          // R6 Y power of two
      apply(1, 2, 32'h8, 1, 32'h4, 1);                 // R6 X first
      apply(1, 3, 32'h0, 1, 32'h0, 1);                 // R7 divide by zero
      apply(1, 3, 32'h0, 1, 32'h5, 1);                 // R7
      apply(1, 3, 32'h0, 1, 32'h5, 0);                 // R7 divisor unknown
      apply(1, 3, 32'h99, 1, 32'h99, 1);               // R7 one
      apply(1, 3, 32'h1000, 1, 32'h10, 1);             // R8
      apply(1, 4, 32'h0, 1, 32'h3, 0);                 // R9
      apply(1, 5, 32'h3, 0, 32'hffffffff, 1);          // R9
      apply(1, 4, 32'hffffffff, 1, 32'h1357, 1);       // R10
      apply(1, 5, 32'h2468, 1, 32'h2468, 1);           // R10
      apply(1, 6, 32'hffffffff, 1, 32'h0f0f, 1);       // R10
      apply(1, 6, 32'h1111, 1, 32'h1111, 1);           // R10
      apply(1, 7, 32'h0, 1, 32'h3, 0);                 // R11
      apply(1, 8, 32'h1234, 1, 32'h40, 1);             // R11 upper bits ignored
      apply(1, 8, 32'h1234, 1, 32'h41, 1);             // R11 normal
      apply(1, 9, 32'hffffffff, 1, 32'h3, 0);          // R12
      apply(1, 9, 32'h8000, 1, 32'h20, 1);             // R12
      apply(1, 12, 32'h5, 1, 32'h6, 1);                // R13 unused opcode
      apply(1, 12, 32'h5, 1, 32'h6, 0);                // R13 waits
      apply(0, 2, 32'h0, 1, 32'h0, 1);                 // R1 idle after request

      for (int n = 0; n < 4000; n++) begin
         logic [W-1:0] xa, yb;
         xa = pick(W'($urandom));
         yb = pick(xa);
         apply($urandom_range(0, 9) != 0, $urandom_range(0, 11), xa,
               $urandom_range(0, 3) != 0, yb, $urandom_range(0, 3) != 0);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish (got hang, exp completion)");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule